// File: doc/BRIEF.md
# Three-Master Scan Path Request Arbiter

This block decides which of three test masters owns a shared scan path. Each master raises an active-low request; the arbiter answers with an active-high grant, and at most one grant is ever asserted. When the path is free and several masters ask at once, the lowest-numbered one wins. A master keeps the path until it drops its own request; nobody is preempted. A request pin left floating reads high, so that port never asks and acts as a slave.

Two side outputs go with the grant. An active-low collision flag reports, one clock later, any cycle in which two or more requests were low together. An active-low activity output is built from two mode pins, the top bit of the scan instruction register and whether any master currently holds a grant. With no holder it is always high. With a holder, mode 11 keeps it high, any mode with the upper pin at 0 passes the instruction bit straight through, and mode 10 passes its inverse.

Top module: `jtag_master_arbiter`

## Requirements
- R1: While reset is low, all grants are 0 and the collision flag and the activity output are both high.
- R2: At most one grant bit is 1 in any cycle.
- R3: When no master holds a grant and exactly one request is low at a clock edge, that master's grant is 1 after the edge.
- R4: When no master holds a grant and several requests are low at a clock edge, only the grant of the lowest-numbered requester (bit 0 before bit 1 before bit 2) is 1 after the edge.
- R5: A master whose grant is 1 and whose request is still low at a clock edge keeps its grant after that edge, whatever the other requests do.
- R6: When the holder's request is high at a clock edge, after that edge the grant moves to the lowest-numbered master whose request is low, or all grants go to 0 if none is.
- R7: The collision flag after a clock edge is 0 if two or more requests were low at that edge and 1 otherwise.
- R8: The activity output is 1 whenever all grants are 0, whatever the mode pins and instruction bit hold.
- R9: With mode_hi=1 and mode_lo=1 the activity output is 1.
- R10: With a grant held and mode_hi=0, the activity output equals ir_msb.
- R11: With a grant held, mode_hi=1 and mode_lo=0, the activity output equals the inverse of ir_msb.
- R12: A master whose request was high at a clock edge holds no grant after that edge, so a floating (high) request pin is never granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; grants and the collision flag update on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | 3 | Request from each master, active low, bit i for master i |
| mode_hi | input | 1 | Upper mode pin for the activity output |
| mode_lo | input | 1 | Lower mode pin for the activity output |
| ir_msb | input | 1 | Top bit of the scan instruction register |
| grant | output | 3 | Grant to each master, active high, one-hot or zero |
| conflict_n | output | 1 | Low when two or more requests were low at the last edge |
| act_n | output | 1 | Activity output, active low |

## Verification
A wrong holder register shows on the grant pins at the very next edge: a lost holder frees the path to a lower requester, a stuck holder blocks a release, and both differ from the model within one cycle of the stimulus that exposes them. The sweep walks every pair of consecutive request patterns, so each holder can meet every follow-up pattern, and a wrong priority or hold rule is caught in the cycle it first matters. A wrong collision register shows on conflict_n one edge after the offending pattern, and a wrong activity decode shows at once on act_n because every mode and instruction-bit value is crossed with both a held and a free path.

// File: rtl/jarb_pkg.sv
package jarb_pkg;

    localparam int unsigned DEF_MASTERS = 3;

    // Mode pin pair {mode_hi, mode_lo}; the values are the pin levels.
    typedef enum logic [1:0] {
        ACT_PASS_A = 2'b00,
        ACT_PASS_B = 2'b01,
        ACT_INVERT = 2'b10,
        ACT_QUIET  = 2'b11
    } act_mode_e;

endpackage

// File: rtl/jarb_pick_lowest.sv
module jarb_pick_lowest #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick
);

    // lower_any[i] is set when some master below i requests.
    logic [N:0] lower_any;

    assign lower_any[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign lower_any[i+1] = lower_any[i] | req[i];
        assign pick[i]        = req[i] & ~lower_any[i];
    end

endmodule

// File: rtl/jarb_next_grant.sv
module jarb_next_grant #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] grant_q,
    output logic [N-1:0] grant_d
);

    logic [N-1:0] still_asking;
    logic [N-1:0] fresh_pick;
    logic         keep_holder;

    assign still_asking = grant_q & req;
    assign keep_holder  = |still_asking;

    jarb_pick_lowest #(.N(N)) u_pick (
        .req  (req),
        .pick (fresh_pick)
    );

    always_comb begin
        if (keep_holder) begin
            grant_d = grant_q;
        end else begin
            grant_d = fresh_pick;
        end
    end

endmodule

// File: rtl/jarb_collide.sv
module jarb_collide #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] req,
    output logic         multi
);

    localparam int unsigned CW = $clog2(N + 1);

    logic [CW-1:0] count;

    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CW'(req[i]);
        end
        multi = (count > CW'(1));
    end

endmodule

// File: rtl/jarb_act_decode.sv
module jarb_act_decode
    import jarb_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       ir_msb,
    input  logic       active,
    output logic       act_n
);

    act_mode_e mode_e;

    assign mode_e = act_mode_e'(mode);

    always_comb begin
        act_n = 1'b1;
        if (active) begin
            unique case (mode_e)
                ACT_PASS_A, ACT_PASS_B: act_n = ir_msb;
                ACT_INVERT:             act_n = ~ir_msb;
                ACT_QUIET:              act_n = 1'b1;
                default:                act_n = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/jtag_master_arbiter.sv
module jtag_master_arbiter #(
    parameter int unsigned N_MASTERS = jarb_pkg::DEF_MASTERS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req_n,
    input  logic                 mode_hi,
    input  logic                 mode_lo,
    input  logic                 ir_msb,
    output logic [N_MASTERS-1:0] grant,
    output logic                 conflict_n,
    output logic                 act_n
);

    typedef struct packed {
        logic [N_MASTERS-1:0] grant;
        logic                 collide;
    } arb_state_t;

    arb_state_t           state_d;
    arb_state_t           state_q;
    logic [N_MASTERS-1:0] req_active;
    logic [N_MASTERS-1:0] grant_next;
    logic                 multi_req;
    logic                 path_held;

    assign req_active = ~req_n;

    jarb_next_grant #(.N(N_MASTERS)) u_next (
        .req     (req_active),
        .grant_q (state_q.grant),
        .grant_d (grant_next)
    );

    jarb_collide #(.N(N_MASTERS)) u_collide (
        .req   (req_active),
        .multi (multi_req)
    );

    always_comb begin
        state_d         = state_q;
        state_d.grant   = grant_next;
        state_d.collide = multi_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign path_held = |state_q.grant;

    jarb_act_decode u_act (
        .mode   ({mode_hi, mode_lo}),
        .ir_msb (ir_msb),
        .active (path_held),
        .act_n  (act_n)
    );

    assign grant      = state_q.grant;
    assign conflict_n = ~state_q.collide;

endmodule

// File: rtl/jarb_checker.sv
module jarb_checker #(
    parameter int unsigned N = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req_n,
    input logic         mode_hi,
    input logic         mode_lo,
    input logic         ir_msb,
    input logic [N-1:0] grant,
    input logic         conflict_n,
    input logic         act_n
);

    assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_collide_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~req_n) > 1) |=> !conflict_n);

    assert_collide_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~req_n) <= 1) |=> conflict_n);

    assert_idle_act_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |-> act_n);

    assert_quiet_act_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_hi && mode_lo) |-> act_n);

    assert_pass_act_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && !mode_hi) |-> (act_n == ir_msb));

    assert_invert_act_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && mode_hi && !mode_lo) |-> (act_n == !ir_msb));

    for (genvar i = 0; i < N; i++) begin : g_per_master
        localparam logic [N-1:0] LOWER = N'((1 << i) - 1);

        assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[i] && !req_n[i]) |=> grant[i]);

        assert_needs_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
            req_n[i] |=> !grant[i]);

        assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ((grant == '0) && !req_n[i] && ((~req_n & LOWER) == '0)) |=> grant[i]);
    end

endmodule

bind jtag_master_arbiter jarb_checker #(.N(N_MASTERS)) u_jarb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_n      (req_n),
    .mode_hi    (mode_hi),
    .mode_lo    (mode_lo),
    .ir_msb     (ir_msb),
    .grant      (grant),
    .conflict_n (conflict_n),
    .act_n      (act_n)
);

// File: tb/test_jtag_master_arbiter.sv
`timescale 1ns/1ps
module test_jtag_master_arbiter;

    localparam int NM = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NM-1:0] req_n = '1;
    logic          mode_hi = 1'b0;
    logic          mode_lo = 1'b0;
    logic          ir_msb = 1'b0;
    logic [NM-1:0] grant;
    logic          conflict_n;
    logic          act_n;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    int  holder   = -1;
    bit  exp_conf = 1'b1;

    always #2.5 clk = ~clk;

    jtag_master_arbiter #(.N_MASTERS(NM)) i_jtag_master_arbiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_n      (req_n),
        .mode_hi    (mode_hi),
        .mode_lo    (mode_lo),
        .ir_msb     (ir_msb),
        .grant      (grant),
        .conflict_n (conflict_n),
        .act_n      (act_n)
    );

    task automatic check(input string tag, input logic [31:0] actual, input logic [31:0] expected);
        n_checks++;
        if (actual !== expected) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actual, expected, $time);
        end
    endtask

    function automatic logic expect_act(input bit held, input logic m1, input logic m0, input logic msb);
        if (!held)   return 1'b1;
        if (m1 & m0) return 1'b1;
        if (!m1)     return msb;
        return ~msb;
    endfunction

    function automatic logic [NM-1:0] onehot_of(input int h);
        logic [NM-1:0] v;
        v = '0;
        if (h >= 0) v[h] = 1'b1;
        return v;
    endfunction

    function automatic string act_tag(input bit held, input logic m1, input logic m0);
        if (!held)    return "R8";
        if (m1 && m0) return "R9";
        if (!m1)      return "R10";
        return "R11";
    endfunction

    task automatic apply(input logic [NM-1:0] r, input logic m1, input logic m0, input logic msb);
        int    lows;
        int    prev;
        string gtag;
        @(negedge clk);
        req_n   = r;
        mode_hi = m1;
        mode_lo = m0;
        ir_msb  = msb;
        @(posedge clk);
        lows = 0;
        for (int i = 0; i < NM; i++) if (!r[i]) lows++;
        prev = holder;
        if (holder >= 0 && !r[holder]) begin
            gtag = "R5";
        end else begin
            holder = -1;
            for (int i = NM - 1; i >= 0; i--) if (!r[i]) holder = i;
            if (holder < 0)     gtag = "R12";
            else if (prev >= 0) gtag = "R6";
            else if (lows > 1)  gtag = "R4";
            else                gtag = "R3";
        end
        exp_conf = (lows < 2);
        #1;
        check(gtag, grant, onehot_of(holder));
        check("R2", 32'($countones(grant)) <= 1, 1);
        check("R7", conflict_n, exp_conf);
        check(act_tag(holder >= 0, m1, m0), act_n, expect_act(holder >= 0, m1, m0, msb));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_n = '0;
        #1;
        check("R1", grant, 0);
        check("R1", conflict_n, 1);
        check("R1", act_n, 1);
        @(posedge clk);
        #1;
        check("R1", grant, 0);
        @(negedge clk);
        rst_n  = 1'b1;
        req_n  = '1;
        holder = -1;
    endtask

    initial begin
        do_reset();
        // Every ordered pair of request patterns, mode and bit varied along the way.
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                apply(NM'(a), 1'((a + b) >> 1), 1'(a + b), 1'(b ^ (a >> 1)));
                apply(NM'(b), 1'(b >> 1), 1'(a), 1'(a ^ b));
            end
        end
        // Hold a master, then cross every mode with both instruction-bit values.
        apply(3'b101, 1'b0, 1'b0, 1'b0);
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                apply(3'b001, 1'(m >> 1), 1'(m), 1'(s));
            end
        end
        // Free path: output stays high for every mode and bit (R8).
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                apply(3'b111, 1'(m >> 1), 1'(m), 1'(s));
            end
        end
        // Floating request pin never granted while others come and go (R12).
        for (int k = 0; k < 4; k++) apply({1'b1, 2'(k)}, 1'b0, 1'b1, 1'b1);
        // Reset in the middle of a held grant.
        apply(3'b011, 1'b0, 1'b0, 1'b1);
        do_reset();
        apply(3'b110, 1'b1, 1'b0, 1'b1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule